// File: doc/BRIEF.md
# SPI Master with Streaming Chip Select

This block is a byte-wide SPI master for a chip's peripheral fabric. A host loads bytes into a one-deep transmit holding buffer with a write strobe. The shift engine takes each byte from that buffer and sends it MSB first on `mosi`. At the same time it shifts a byte in from `miso`. Each finished input byte lands in a receive holding register. A valid flag and an overrun flag go with that register, and a read strobe clears both. Because the buffer sits in front of the shift register, the host can write the next byte while the current byte is still on the wire.

Two configuration inputs set the behaviour. `cfg_auto_ss` selects whether the engine drives the active-low select itself or the select simply follows a host-held level. `cfg_cont` selects continuous streaming or single-byte transfers.

- **Continuous streaming:** at each byte boundary the engine checks the buffer. If a byte is waiting, the engine keeps going with no break in the clock. If not, it ends the burst.
- **Single-byte transfers:** every byte is followed by a fixed idle gap. During the gap the clock is held low and, in automatic mode, the select is high.

A level flag reports that the transmit buffer is empty. The serial clock runs in mode 0, and its half period is set in system cycles by a host input.

Top module: `spi_stream_master`

## Requirements
- R1: Every transfer moves 8 bits. Bits leave on `mosi` MSB first, and `miso` is shifted in MSB first at the same time. `sclk` idles low, `mosi` changes only on a falling edge of `sclk` or before the first rising edge, and `miso` is sampled on each rising edge.
- R2: Each high phase and each low phase of `sclk` lasts `half_div` system clock cycles, for `half_div` of 1 or more. A value of 0 acts as 1. Inside a byte, and across bytes in a continuous burst, consecutive rising edges are `2*half_div` cycles apart.
- R3: With `cfg_auto_ss`=1, `ss_n` goes low in the cycle the engine takes a byte from the buffer. It stays low until the last falling edge of the transfer or burst, and it is high whenever `busy` is low.
- R4: With `cfg_auto_ss`=0, `ss_n` equals `manual_ss_n` at all times, including while a byte shifts.
- R5: With `cfg_cont`=1, a byte found in the buffer at a byte boundary starts shifting at once. `ss_n` stays low across the whole burst, and the rising-edge spacing stays `2*half_div`.
- R6: With `cfg_cont`=1, the burst ends when the buffer is empty at a byte boundary. `ss_n` then rises once and `busy` falls.
- R7: With `cfg_cont`=0, each byte is followed by an idle gap of two `sclk` periods with `sclk` low. In automatic mode, `ss_n` is high between two buffered bytes for exactly `4*half_div+1` system cycles.
- R8: `tx_empty_irq` is 1 after reset. It reads 0 in the cycle after a `tx_wr` strobe, and it returns to 1 in the cycle after the engine takes the byte.
- R9: A byte written while another byte is shifting is held and sent as the next byte, in order.
- R10: At the 8th falling edge of a transfer, the received byte is copied to `rx_data` and `rx_valid` is set. An `rx_rd` strobe clears `rx_valid` in the next cycle.
- R11: If a byte completes while `rx_valid` is still 1 and no read is strobed, `rx_overrun` is set and `rx_data` takes the newer byte. `rx_rd` clears `rx_overrun`.
- R12: `busy` is 1 from the cycle the engine takes a byte until the last falling edge of the transfer or burst. It is 0 during idle and during the single-byte gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_auto_ss | input | 1 | 1: engine drives select; 0: select follows `manual_ss_n` |
| cfg_cont | input | 1 | 1: continuous streaming; 0: single-byte transfers with gap |
| manual_ss_n | input | 1 | Host-held select level used when `cfg_auto_ss`=0 |
| half_div | input | DIV_W | `sclk` half period in system cycles |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | DATA_W | Byte to load into the transmit buffer |
| tx_empty_irq | output | 1 | Level flag: transmit buffer empty |
| rx_rd | input | 1 | Read strobe; clears `rx_valid` and `rx_overrun` |
| rx_data | output | DATA_W | Receive holding register |
| rx_valid | output | 1 | Unread byte in `rx_data` |
| rx_overrun | output | 1 | A byte replaced an unread one |
| busy | output | 1 | Transfer or burst in progress |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
A slave model in the bench decodes `mosi` on rising `sclk` edges and drives a distinct, index-derived byte on `miso` for every transfer. This exposes bit-order errors and shows whether received bytes are matched to the correct transfer.

Three main patterns are used:
- A lone byte, which checks the flag timing.
- Two buffered bytes in single-byte mode with `half_div`=3, which isolates the gap length and select toggling.
- A four-byte continuous burst with `half_div`=2, which checks the unbroken clock spacing, the single select release and overrun, since the bytes are not read.

A manual-select run flips the host level in the middle of a byte to show that the engine does not touch the select.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;
   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_SHIFT = 2'd1,
      ENG_GAP   = 2'd2
   } eng_state_t;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim;

   // a zero divider acts as one
   assign lim  = (half_div == '0) ? DIV_W'(1) : half_div;
   assign tick = run && (cnt_q == lim - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/spi_tx_buffer.sv
module spi_tx_buffer #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic              full,
   output logic [DATA_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full  <= 1'b0;
         rdata <= '0;
      end else begin
         // a write in the same cycle as a pop refills the slot
         if (wr) begin
            full  <= 1'b1;
            rdata <= wdata;
         end else if (pop) begin
            full  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              shift,
   input  logic              sample,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_word
);
   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;

   assign mosi    = tx_sh[DATA_W-1];
   assign rx_word = rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
      end else if (load) begin
         tx_sh <= load_data;
      end else if (shift) begin
         tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh <= '0;
      end else if (sample) begin
         rx_sh <= {rx_sh[DATA_W-2:0], miso};
      end
   end
endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              rd,
   output logic [DATA_W-1:0] data,
   output logic              valid,
   output logic              overrun
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data    <= '0;
         valid   <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (capture) begin
            data  <= cap_data;
            valid <= 1'b1;
         end else if (rd) begin
            valid <= 1'b0;
         end
         if (rd) begin
            overrun <= 1'b0;
         end else if (capture && valid) begin
            overrun <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_stream_master.sv
module spi_stream_master
   import spi_stream_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DIV_W     = 8,
   parameter int GAP_SCLKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_auto_ss,
   input  logic              cfg_cont,
   input  logic              manual_ss_n,
   input  logic [DIV_W-1:0]  half_div,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_empty_irq,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_overrun,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              ss_n
);
   localparam int CNT_W     = $clog2(DATA_W);
   localparam int GAP_TICKS = 2 * GAP_SCLKS;
   localparam int GAP_W     = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
      if (GAP_SCLKS < 1) begin : g_bad_gap
         $error("GAP_SCLKS must be at least 1");
      end
   endgenerate

   eng_state_t        state_q, state_d;
   logic [CNT_W-1:0]  bit_q, bit_d;
   logic [GAP_W-1:0]  gap_q, gap_d;
   logic              sclk_q, sclk_d;
   logic              tick;
   logic              buf_full;
   logic [DATA_W-1:0] buf_data;
   logic              pop, do_shift, do_sample, byte_end;
   logic [DATA_W-1:0] rx_word;

   spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (state_q != ENG_IDLE),
      .half_div (half_div),
      .tick     (tick)
   );

   spi_tx_buffer #(.DATA_W(DATA_W)) u_txbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (tx_wr),
      .wdata (tx_data),
      .pop   (pop),
      .full  (buf_full),
      .rdata (buf_data)
   );

   spi_shift_core #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (pop),
      .load_data (buf_data),
      .shift     (do_shift),
      .sample    (do_sample),
      .miso      (miso),
      .mosi      (mosi),
      .rx_word   (rx_word)
   );

   spi_rx_hold #(.DATA_W(DATA_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (byte_end),
      .cap_data (rx_word),
      .rd       (rx_rd),
      .data     (rx_data),
      .valid    (rx_valid),
      .overrun  (rx_overrun)
   );

   always_comb begin
      state_d   = state_q;
      bit_d     = bit_q;
      gap_d     = gap_q;
      sclk_d    = sclk_q;
      pop       = 1'b0;
      do_shift  = 1'b0;
      do_sample = 1'b0;
      byte_end  = 1'b0;
      unique case (state_q)
         ENG_IDLE: begin
            if (buf_full) begin
               pop     = 1'b1;
               bit_d   = '0;
               sclk_d  = 1'b0;
               state_d = ENG_SHIFT;
            end
         end
         ENG_SHIFT: begin
            if (tick) begin
               if (!sclk_q) begin
                  sclk_d    = 1'b1;
                  do_sample = 1'b1;
               end else begin
                  sclk_d = 1'b0;
                  if (bit_q == CNT_W'(DATA_W - 1)) begin
                     byte_end = 1'b1;
                     bit_d    = '0;
                     if (cfg_cont && buf_full) begin
                        pop = 1'b1;
                     end else if (cfg_cont) begin
                        state_d = ENG_IDLE;
                     end else begin
                        gap_d   = '0;
                        state_d = ENG_GAP;
                     end
                  end else begin
                     bit_d    = bit_q + CNT_W'(1);
                     do_shift = 1'b1;
                  end
               end
            end
         end
         ENG_GAP: begin
            if (tick) begin
               if (gap_q == GAP_W'(GAP_TICKS - 1)) begin
                  state_d = ENG_IDLE;
               end else begin
                  gap_d = gap_q + GAP_W'(1);
               end
            end
         end
         default: state_d = ENG_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         bit_q   <= '0;
         gap_q   <= '0;
         sclk_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         bit_q   <= bit_d;
         gap_q   <= gap_d;
         sclk_q  <= sclk_d;
      end
   end

   assign busy         = (state_q == ENG_SHIFT);
   assign sclk         = sclk_q;
   assign ss_n         = cfg_auto_ss ? ~busy : manual_ss_n;
   assign tx_empty_irq = ~buf_full;
endmodule

// File: rtl/spi_stream_master_chk.sv
module spi_stream_master_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_auto_ss,
   input logic manual_ss_n,
   input logic tx_wr,
   input logic tx_empty_irq,
   input logic rx_rd,
   input logic rx_valid,
   input logic rx_overrun,
   input logic busy,
   input logic sclk,
   input logic mosi,
   input logic ss_n
);
   // R3
   auto_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_auto_ss && !busy) |-> ss_n);

   // R4
   manual_sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_auto_ss |-> (ss_n == manual_ss_n));

   // R1
   sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   // R1
   mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   // R8
   irq_clear_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr |=> !tx_empty_irq);

   // R10
   read_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !busy) |=> !rx_valid);

   // R11
   overrun_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_overrun) |-> $past(rx_valid));
endmodule

bind spi_stream_master spi_stream_master_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_auto_ss  (cfg_auto_ss),
   .manual_ss_n  (manual_ss_n),
   .tx_wr        (tx_wr),
   .tx_empty_irq (tx_empty_irq),
   .rx_rd        (rx_rd),
   .rx_valid     (rx_valid),
   .rx_overrun   (rx_overrun),
   .busy         (busy),
   .sclk         (sclk),
   .mosi         (mosi),
   .ss_n         (ss_n)
);

// File: tb/spi_stream_master_bench.sv
module spi_stream_master_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_auto_ss = 1'b1;
   logic       cfg_cont = 1'b0;
   logic       manual_ss_n = 1'b1;
   logic [7:0] half_div = 8'd2;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_empty_irq;
   logic       rx_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_valid, rx_overrun, busy, sclk, mosi, miso, ss_n;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   spi_stream_master u_spi_stream_master (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_auto_ss  (cfg_auto_ss),
      .cfg_cont     (cfg_cont),
      .manual_ss_n  (manual_ss_n),
      .half_div     (half_div),
      .tx_wr        (tx_wr),
      .tx_data      (tx_data),
      .tx_empty_irq (tx_empty_irq),
      .rx_rd        (rx_rd),
      .rx_data      (rx_data),
      .rx_valid     (rx_valid),
      .rx_overrun   (rx_overrun),
      .busy         (busy),
      .sclk         (sclk),
      .mosi         (mosi),
      .miso         (miso),
      .ss_n         (ss_n)
   );

   function automatic logic [7:0] slv_byte(int i);
      return 8'((i * 73) + 8'h5A);
   endfunction

   // slave model and line monitor, sampled on the falling system edge
   logic [7:0] mon_out [0:63];
   int   mon_n = 0, mon_bit = 0, cyc = 0, last_rise = 0;
   int   ss_run = 0, last_ss_run = 0, ss_rises = 0, pcnt = 0, pbad = 0;
   bit   have_last = 1'b0, gap_seen = 1'b1, chk_period = 1'b0;
   logic prev_sclk = 1'b0, prev_ss = 1'b1;
   logic [7:0] mon_sh = 8'h00;
   logic [7:0] miso_byte;

   assign miso_byte = slv_byte(mon_n);
   assign miso      = miso_byte[3'(7 - mon_bit)];

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (sclk && !prev_sclk) begin
            if (chk_period && have_last && !gap_seen) begin
               pcnt <= pcnt + 1;
               if (cyc - last_rise != 2 * int'(half_div)) pbad <= pbad + 1;
            end
            last_rise <= cyc;
            have_last <= 1'b1;
            gap_seen  <= ss_n;
            if (mon_bit == 7) begin
               mon_out[mon_n[5:0]] <= {mon_sh[6:0], mosi};
               mon_n   <= mon_n + 1;
               mon_bit <= 0;
            end else begin
               mon_bit <= mon_bit + 1;
            end
            mon_sh <= {mon_sh[6:0], mosi};
         end else if (ss_n) begin
            gap_seen <= 1'b1;
         end
         if (ss_n) begin
            ss_run <= ss_run + 1;
            if (!prev_ss) ss_rises <= ss_rises + 1;
         end else if (prev_ss) begin
            last_ss_run <= ss_run;
            ss_run <= 0;
         end
      end
      prev_sclk <= sclk;
      prev_ss   <= ss_n;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic host_write(input logic [7:0] b);
      @(negedge clk);
      tx_wr   = 1'b1;
      tx_data = b;
      @(negedge clk);
      tx_wr   = 1'b0;
   endtask

   task automatic host_read();
      @(negedge clk);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic wait_irq();
      while (!tx_empty_irq) @(negedge clk);
   endtask

   task automatic wait_bytes(input int n);
      while (mon_n < n) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (4 * int'(half_div) + 6) @(negedge clk);
   endtask

   task automatic test_reset();
      chk(ss_n == 1'b1, "R3", "ss_n after reset", ss_n, 1);
      chk(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
      chk(busy == 1'b0, "R12", "busy after reset", busy, 0);
      chk(tx_empty_irq == 1'b1, "R8", "irq after reset", tx_empty_irq, 1);
      chk(rx_valid == 1'b0, "R10", "rx_valid after reset", rx_valid, 0);
   endtask

   task automatic test_lone_byte();
      int base = mon_n;
      half_div = 8'd2;
      host_write(8'h81);
      chk(tx_empty_irq == 1'b0, "R8", "irq after write", tx_empty_irq, 0);
      @(negedge clk);
      chk(tx_empty_irq == 1'b1, "R8", "irq after take", tx_empty_irq, 1);
      chk(busy == 1'b1, "R12", "busy at start", busy, 1);
      chk(ss_n == 1'b0, "R3", "ss_n at start", ss_n, 0);
      wait_bytes(base + 1);
      wait_idle();
      chk(busy == 1'b0, "R12", "busy after byte", busy, 0);
      chk(mon_out[base] == 8'h81, "R1", "mosi byte", mon_out[base], 8'h81);
      chk(rx_valid == 1'b1, "R10", "rx_valid set", rx_valid, 1);
      chk(rx_data == slv_byte(base), "R10", "rx byte", rx_data, slv_byte(base));
      host_read();
      chk(rx_valid == 1'b0, "R10", "rx_valid after read", rx_valid, 0);
   endtask

   task automatic test_single_pair();
      int base = mon_n;
      int p0 = pcnt, b0 = pbad;
      half_div   = 8'd3;
      cfg_cont   = 1'b0;
      chk_period = 1'b1;
      host_write(8'hC3);
      @(negedge clk);
      host_write(8'h3C);
      wait_bytes(base + 1);
      while (!rx_valid) @(negedge clk);
      chk(rx_data == slv_byte(base), "R10", "single first rx", rx_data, slv_byte(base));
      host_read();
      wait_bytes(base + 2);
      wait_idle();
      chk_period = 1'b0;
      chk(mon_out[base] == 8'hC3, "R9", "single first byte", mon_out[base], 8'hC3);
      chk(mon_out[base + 1] == 8'h3C, "R9", "single second byte", mon_out[base + 1], 8'h3C);
      chk(last_ss_run == 4 * 3 + 1, "R7", "gap select high cycles", last_ss_run, 13);
      chk(pbad == b0 && pcnt - p0 >= 14, "R2", "sclk spacing half_div=3", pbad - b0, 0);
      chk(rx_data == slv_byte(base + 1) && !rx_overrun, "R10", "single second rx",
          rx_data, slv_byte(base + 1));
      host_read();
   endtask

   task automatic test_burst();
      int base = mon_n;
      int r0, p0, b0;
      logic [7:0] pat [0:3];
      pat[0] = 8'hA5; pat[1] = 8'h0F; pat[2] = 8'hF0; pat[3] = 8'h5A;
      half_div   = 8'd2;
      cfg_cont   = 1'b1;
      @(negedge clk);
      r0 = ss_rises; p0 = pcnt; b0 = pbad;
      chk_period = 1'b1;
      for (int i = 0; i < 4; i++) begin
         wait_irq();
         host_write(pat[i]);
      end
      wait_bytes(base + 4);
      wait_idle();
      chk_period = 1'b0;
      for (int i = 0; i < 4; i++) begin
         chk(mon_out[base + i] == pat[i], "R9", "burst byte order", mon_out[base + i], pat[i]);
      end
      chk(ss_rises - r0 == 1, "R5", "select rises per burst", ss_rises - r0, 1);
      chk(pbad == b0 && pcnt - p0 >= 28, "R5", "no gap in burst", pbad - b0, 0);
      chk(busy == 1'b0 && ss_n == 1'b1, "R6", "burst ended", {busy, ss_n}, 2'b01);
      chk(rx_overrun == 1'b1, "R11", "overrun set", rx_overrun, 1);
      chk(rx_data == slv_byte(base + 3), "R11", "newest rx kept", rx_data, slv_byte(base + 3));
      host_read();
      chk(rx_overrun == 1'b0, "R11", "overrun cleared", rx_overrun, 0);
      cfg_cont = 1'b0;
   endtask

   task automatic test_manual();
      int base = mon_n;
      cfg_auto_ss = 1'b0;
      manual_ss_n = 1'b0;
      half_div    = 8'd4;
      host_write(8'h96);
      while (!busy) @(negedge clk);
      chk(ss_n == 1'b0, "R4", "manual low", ss_n, 0);
      manual_ss_n = 1'b1;
      @(negedge clk);
      chk(ss_n == 1'b1 && busy == 1'b1, "R4", "manual high mid-byte", {ss_n, busy}, 2'b11);
      wait_bytes(base + 1);
      wait_idle();
      chk(mon_out[base] == 8'h96, "R1", "manual byte", mon_out[base], 8'h96);
      chk(ss_n == 1'b1, "R4", "manual after", ss_n, 1);
      host_read();
      cfg_auto_ss = 1'b1;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_lone_byte();
      test_single_pair();
      test_burst();
      test_manual();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end
endmodule